// File: doc/BRIEF.md
# Interrupt Entry Sequencer for an 8-bit CPU

This block decides when an 8-bit processor core leaves its instruction stream for an interrupt, a software break or a soft reset, and it performs the bus work of that entry. It watches an active-low non-maskable line, which is edge-latched, and an active-low maskable line, which is level-sensitive. The core offers it instruction boundaries, break requests and reset requests. When something is pending and the block is idle, it takes a snapshot of the program counter, stack pointer and status. It then drives a single-port memory through a request/ready handshake.

For an interrupt or a break, the block writes three bytes into the stack page and then reads a two-byte vector. For a reset request, it reads the vector only. It then hands the new program counter, stack pointer and status back to the core, together with a one-cycle done pulse. A small combinational path also serves the return-from-interrupt sequence. It merges a status byte pulled from the stack with the two bits that are never restored.

Top module: `irq_entry_unit`

## Requirements
- R1: Once rst_n is released, the outputs hold their power-up values: busy=0, done=0, mem_req=0, new_psr=0x34, new_sp=0xFD.
- R2: The non-maskable request is latched when nmi_n is 0 in a cycle after a cycle in which it was 1. The latch stays set until it is serviced. A line held low does not trigger again.
- R3: The maskable request is pending in every cycle in which irq_n is 0 and status bit 2 (the I flag) of cur_psr is 0. While that bit is 1, the line is ignored.
- R4: Priority is reset request, then non-maskable, then break, then maskable. A reset request is taken in any idle cycle. The other three are taken only in an idle cycle with boundary=1. A request that loses stays pending if it is latched.
- R5: An interrupt or break entry writes, in this order, PC[15:8], then PC[7:0], then cur_psr OR 0x30. Each write goes to address 0x0100+SP, SP is decremented by one after each write, and new_sp equals the SP at capture minus 3 (modulo 256).
- R6: The vector is read low address first, then high address. The low addresses are 0xFFFA for non-maskable, 0xFFFE for maskable and break, and 0xFFFC for reset. new_pc = {high byte, low byte}.
- R7: new_psr equals the captured status with bit 2 set and every other bit unchanged.
- R8: A reset request makes no memory write and reads only the vector. new_sp equals the captured SP minus 3 (modulo 256).
- R9: busy is 1 from the cycle after acceptance until the last vector read completes. done is a single-cycle pulse in the first cycle with busy=0. new_pc, new_sp and new_psr are valid with done. Each access takes one cycle plus the memory's wait cycles.
- R10: While mem_req=1 and mem_ready=0, mem_addr, mem_we and mem_wdata hold their values. An access completes on the edge where mem_req and mem_ready are both 1. Read data is taken from mem_rdata on that edge.
- R11: restored_psr equals pulled_psr with bits 5 and 4 replaced by the bits of cur_psr.
- R12: The non-maskable latch is cleared in the cycle that entry is accepted. A new falling edge during the entry sets it again, and it is serviced at a later boundary.
- R13: entry_src reports the accepted source from the cycle after acceptance: 0 reset, 1 non-maskable, 2 break, 3 maskable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_n | input | 1 | Non-maskable request line, active low |
| irq_n | input | 1 | Maskable request line, active low |
| boundary | input | 1 | Core is at an instruction boundary |
| brk_req | input | 1 | Software break request |
| reset_req | input | 1 | Soft reset request |
| cur_pc | input | 16 | Current program counter |
| cur_sp | input | 8 | Current stack pointer |
| cur_psr | input | 8 | Current status byte |
| pulled_psr | input | 8 | Status byte read back from the stack |
| restored_psr | output | 8 | Status to load on return |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Access completes this cycle |
| busy | output | 1 | Entry sequence in progress |
| done | output | 1 | New state valid, one cycle |
| entry_src | output | 2 | Source of the last accepted entry |
| new_pc | output | 16 | Program counter from the vector |
| new_sp | output | 8 | Stack pointer after entry |
| new_psr | output | 8 | Status after entry |

## Verification
The assertions assume that the memory never withdraws mem_ready once it has been given. They also assume a completed access is never reported without a request, and that the default stack page is in use. The memory model in the stimulus raises ready only while a request is present, after a chosen number of wait cycles (0 to 3), and drops it once the access has been taken. All inputs change on the falling clock edge, and with no synchronizer stages each line reaches the detector on the next rising edge.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;

   localparam int DATA_W = 8;
   localparam int ADDR_W = 16;

   // Status bits that are forced on push and never restored on pull.
   localparam logic [DATA_W-1:0] FIXED_BITS = 8'h30;

   typedef enum logic [1:0] {
      SRC_RST = 2'd0,
      SRC_NMI = 2'd1,
      SRC_BRK = 2'd2,
      SRC_IRQ = 2'd3
   } src_e;

   typedef enum logic [2:0] {
      ST_IDLE   = 3'd0,
      ST_PUSH_H = 3'd1,
      ST_PUSH_L = 3'd2,
      ST_PUSH_P = 3'd3,
      ST_VEC_L  = 3'd4,
      ST_VEC_H  = 3'd5
   } st_e;

   function automatic logic [DATA_W-1:0] merge_pulled(
      input logic [DATA_W-1:0] pulled,
      input logic [DATA_W-1:0] current);
      return (pulled & ~FIXED_BITS) | (current & FIXED_BITS);
   endfunction

endpackage

// File: rtl/irqseq_sync.sv
module irqseq_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] din,
   output logic [WIDTH-1:0] dout
);

   generate
      if (STAGES == 0) begin : g_direct
         assign dout = din;
      end else begin : g_chain
         logic [WIDTH-1:0] chain_q [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < STAGES; s++) chain_q[s] <= '1;
            end else begin
               chain_q[0] <= din;
               for (int s = 1; s < STAGES; s++) chain_q[s] <= chain_q[s-1];
            end
         end
         assign dout = chain_q[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/irqseq_detect.sv
module irqseq_detect
   import irqseq_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic nmi_l,
   input  logic irq_l,
   input  logic i_mask,
   input  logic boundary,
   input  logic idle,
   input  logic brk_req,
   input  logic reset_req,
   output logic accept,
   output src_e src
);

   logic nmi_prev_q;
   logic nmi_pend_q;
   logic irq_lvl;
   logic nmi_fall;

   assign nmi_fall = nmi_prev_q & ~nmi_l;
   assign irq_lvl  = ~irq_l & ~i_mask;

   always_comb begin
      accept = 1'b0;
      src    = SRC_RST;
      if (idle) begin
         if (reset_req) begin
            accept = 1'b1;
            src    = SRC_RST;
         end else if (boundary) begin
            if (nmi_pend_q) begin
               accept = 1'b1;
               src    = SRC_NMI;
            end else if (brk_req) begin
               accept = 1'b1;
               src    = SRC_BRK;
            end else if (irq_lvl) begin
               accept = 1'b1;
               src    = SRC_IRQ;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmi_prev_q <= 1'b1;
         nmi_pend_q <= 1'b0;
      end else begin
         nmi_prev_q <= nmi_l;
         if (nmi_fall) begin
            nmi_pend_q <= 1'b1;
         end else if (accept && src == SRC_NMI) begin
            nmi_pend_q <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/irqseq_engine.sv
module irqseq_engine
   import irqseq_pkg::*;
#(
   parameter logic [ADDR_W-1:0] VEC_NMI    = 16'hFFFA,
   parameter logic [ADDR_W-1:0] VEC_RST    = 16'hFFFC,
   parameter logic [ADDR_W-1:0] VEC_IRQ    = 16'hFFFE,
   parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
   parameter logic [DATA_W-1:0] PSR_POR    = 8'h34,
   parameter logic [DATA_W-1:0] SP_POR     = 8'hFD,
   parameter int                I_BIT      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  src_e              src,
   input  logic [ADDR_W-1:0] cur_pc,
   input  logic [DATA_W-1:0] cur_sp,
   input  logic [DATA_W-1:0] cur_psr,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic              mem_ready,
   output logic              idle,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              done,
   output logic [1:0]        entry_src,
   output logic [ADDR_W-1:0] new_pc,
   output logic [DATA_W-1:0] new_sp,
   output logic [DATA_W-1:0] new_psr
);

   localparam logic [DATA_W-1:0] I_MASK   = DATA_W'(1) << I_BIT;
   localparam logic [DATA_W-1:0] RST_DROP = DATA_W'(3);

   st_e               st_q, st_d;
   src_e              src_q;
   logic [ADDR_W-1:0] pc_q;
   logic [DATA_W-1:0] sp_q;
   logic [DATA_W-1:0] psr_q;
   logic [DATA_W-1:0] lo_q;
   logic [ADDR_W-1:0] vec_lo;
   logic              xfer;
   logic              pushing;

   assign idle    = (st_q == ST_IDLE);
   assign xfer    = mem_req & mem_ready;
   assign pushing = (st_q == ST_PUSH_H) || (st_q == ST_PUSH_L) || (st_q == ST_PUSH_P);

   always_comb begin
      unique case (src_q)
         SRC_RST: vec_lo = VEC_RST;
         SRC_NMI: vec_lo = VEC_NMI;
         default: vec_lo = VEC_IRQ;
      endcase
   end

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE:   if (accept) st_d = (src == SRC_RST) ? ST_VEC_L : ST_PUSH_H;
         ST_PUSH_H: if (xfer) st_d = ST_PUSH_L;
         ST_PUSH_L: if (xfer) st_d = ST_PUSH_P;
         ST_PUSH_P: if (xfer) st_d = ST_VEC_L;
         ST_VEC_L:  if (xfer) st_d = ST_VEC_H;
         ST_VEC_H:  if (xfer) st_d = ST_IDLE;
         default:   st_d = ST_IDLE;
      endcase
   end

   always_comb begin
      mem_req   = !idle;
      mem_we    = pushing;
      mem_addr  = '0;
      mem_wdata = '0;
      unique case (st_q)
         ST_PUSH_H: begin
            mem_addr  = {STACK_PAGE, sp_q};
            mem_wdata = pc_q[ADDR_W-1:DATA_W];
         end
         ST_PUSH_L: begin
            mem_addr  = {STACK_PAGE, sp_q};
            mem_wdata = pc_q[DATA_W-1:0];
         end
         ST_PUSH_P: begin
            mem_addr  = {STACK_PAGE, sp_q};
            mem_wdata = psr_q | FIXED_BITS;
         end
         ST_VEC_L:  mem_addr = vec_lo;
         ST_VEC_H:  mem_addr = vec_lo | ADDR_W'(1);
         default:   mem_addr = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         src_q   <= SRC_RST;
         pc_q    <= '0;
         sp_q    <= SP_POR;
         psr_q   <= PSR_POR;
         lo_q    <= '0;
         done    <= 1'b0;
         new_pc  <= '0;
         new_sp  <= SP_POR;
         new_psr <= PSR_POR;
      end else begin
         st_q <= st_d;
         done <= 1'b0;
         if (idle && accept) begin
            src_q <= src;
            pc_q  <= cur_pc;
            psr_q <= cur_psr;
            sp_q  <= (src == SRC_RST) ? cur_sp - RST_DROP : cur_sp;
         end
         if (xfer && pushing) sp_q <= sp_q - DATA_W'(1);
         if (xfer && st_q == ST_VEC_L) lo_q <= mem_rdata;
         if (xfer && st_q == ST_VEC_H) begin
            new_pc  <= {mem_rdata, lo_q};
            new_sp  <= sp_q;
            new_psr <= psr_q | I_MASK;
            done    <= 1'b1;
         end
      end
   end

   assign entry_src = src_q;

endmodule

// File: rtl/irq_entry_unit.sv
module irq_entry_unit
   import irqseq_pkg::*;
#(
   parameter logic [15:0] VEC_NMI     = 16'hFFFA,
   parameter logic [15:0] VEC_RST     = 16'hFFFC,
   parameter logic [15:0] VEC_IRQ     = 16'hFFFE,
   parameter logic [7:0]  STACK_PAGE  = 8'h01,
   parameter logic [7:0]  PSR_POR     = 8'h34,
   parameter logic [7:0]  SP_POR      = 8'hFD,
   parameter int          I_BIT       = 2,
   parameter int          SYNC_STAGES = 0
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        nmi_n,
   input  logic        irq_n,
   input  logic        boundary,
   input  logic        brk_req,
   input  logic        reset_req,
   input  logic [15:0] cur_pc,
   input  logic [7:0]  cur_sp,
   input  logic [7:0]  cur_psr,
   input  logic [7:0]  pulled_psr,
   output logic [7:0]  restored_psr,
   output logic        mem_req,
   output logic        mem_we,
   output logic [15:0] mem_addr,
   output logic [7:0]  mem_wdata,
   input  logic [7:0]  mem_rdata,
   input  logic        mem_ready,
   output logic        busy,
   output logic        done,
   output logic [1:0]  entry_src,
   output logic [15:0] new_pc,
   output logic [7:0]  new_sp,
   output logic [7:0]  new_psr
);

   localparam int LINES = 2;

   generate
      if (VEC_NMI[0] || VEC_RST[0] || VEC_IRQ[0]) begin : g_bad_vec
         $error("vector low addresses must be even");
      end
      if (I_BIT < 0 || I_BIT >= DATA_W) begin : g_bad_ibit
         $error("I_BIT out of range");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("SYNC_STAGES must be 0 to 3");
      end
   endgenerate

   logic [LINES-1:0] lines_s;
   logic             idle;
   logic             accept;
   src_e             src;

   irqseq_sync #(
      .WIDTH  (LINES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   ({irq_n, nmi_n}),
      .dout  (lines_s)
   );

   irqseq_detect u_detect (
      .clk       (clk),
      .rst_n     (rst_n),
      .nmi_l     (lines_s[0]),
      .irq_l     (lines_s[1]),
      .i_mask    (cur_psr[I_BIT]),
      .boundary  (boundary),
      .idle      (idle),
      .brk_req   (brk_req),
      .reset_req (reset_req),
      .accept    (accept),
      .src       (src)
   );

   irqseq_engine #(
      .VEC_NMI    (VEC_NMI),
      .VEC_RST    (VEC_RST),
      .VEC_IRQ    (VEC_IRQ),
      .STACK_PAGE (STACK_PAGE),
      .PSR_POR    (PSR_POR),
      .SP_POR     (SP_POR),
      .I_BIT      (I_BIT)
   ) u_engine (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .src       (src),
      .cur_pc    (cur_pc),
      .cur_sp    (cur_sp),
      .cur_psr   (cur_psr),
      .mem_rdata (mem_rdata),
      .mem_ready (mem_ready),
      .idle      (idle),
      .mem_req   (mem_req),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_wdata (mem_wdata),
      .done      (done),
      .entry_src (entry_src),
      .new_pc    (new_pc),
      .new_sp    (new_sp),
      .new_psr   (new_psr)
   );

   assign busy         = !idle;
   assign restored_psr = merge_pulled(pulled_psr, cur_psr);

endmodule

// File: rtl/irqseq_chk.sv
module irqseq_chk #(
   parameter logic [7:0] STACK_PAGE = 8'h01,
   parameter int         I_BIT      = 2
) (
   input logic        clk,
   input logic        rst_n,
   input logic        mem_req,
   input logic        mem_we,
   input logic        mem_ready,
   input logic [15:0] mem_addr,
   input logic [7:0]  mem_wdata,
   input logic        busy,
   input logic        done,
   input logic [1:0]  entry_src,
   input logic [7:0]  new_psr
);

   p_req_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata));

   p_write_page_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> mem_addr[15:8] == STACK_PAGE);

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   p_req_in_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> busy);

   p_iflag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> new_psr[I_BIT]);

   p_reset_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy && entry_src == 2'd0 |-> !mem_we);

endmodule

bind irq_entry_unit irqseq_chk #(
   .STACK_PAGE (STACK_PAGE),
   .I_BIT      (I_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .mem_req   (mem_req),
   .mem_we    (mem_we),
   .mem_ready (mem_ready),
   .mem_addr  (mem_addr),
   .mem_wdata (mem_wdata),
   .busy      (busy),
   .done      (done),
   .entry_src (entry_src),
   .new_psr   (new_psr)
);

// File: tb/irq_entry_unit_test.sv
`timescale 1ns/1ps
module irq_entry_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        nmi_n = 1'b1, irq_n = 1'b1;
   logic        boundary = 1'b0, brk_req = 1'b0, reset_req = 1'b0;
   logic [15:0] cur_pc = '0;
   logic [7:0]  cur_sp = 8'hFD, cur_psr = 8'h34, pulled_psr = '0;
   logic [7:0]  restored_psr;
   logic        mem_req, mem_we;
   logic [15:0] mem_addr;
   logic [7:0]  mem_wdata;
   logic [7:0]  mem_rdata = '0;
   logic        mem_ready = 1'b0;
   logic        busy, done;
   logic [1:0]  entry_src;
   logic [15:0] new_pc;
   logic [7:0]  new_sp, new_psr;

   int nchk = 0, nerr = 0;
   int ws_cfg = 0, wcnt = 0, nlog = 0;
   logic [15:0] log_a [8];
   logic [7:0]  log_d [8];

   always #2.5 clk = ~clk;

   irq_entry_unit uut (
      .clk(clk), .rst_n(rst_n), .nmi_n(nmi_n), .irq_n(irq_n),
      .boundary(boundary), .brk_req(brk_req), .reset_req(reset_req),
      .cur_pc(cur_pc), .cur_sp(cur_sp), .cur_psr(cur_psr),
      .pulled_psr(pulled_psr), .restored_psr(restored_psr),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
      .busy(busy), .done(done), .entry_src(entry_src),
      .new_pc(new_pc), .new_sp(new_sp), .new_psr(new_psr)
   );

   function automatic logic [7:0] mem_val(input logic [15:0] a);
      return a[7:0] ^ 8'hC3;
   endfunction

   // memory model: ready after ws_cfg wait cycles, driven on the falling edge
   always @(negedge clk) begin
      if (mem_ready) begin
         mem_ready = 1'b0;
         wcnt = 0;
      end
      if (mem_req) begin
         if (wcnt >= ws_cfg) begin
            mem_ready = 1'b1;
            mem_rdata = mem_we ? 8'h00 : mem_val(mem_addr);
            if (mem_we && nlog < 8) begin
               log_a[nlog] = mem_addr;
               log_d[nlog] = mem_wdata;
               nlog++;
            end
         end else begin
            wcnt++;
         end
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic summary();
      $display("  Result: errors=%0d of %0d checks", nerr, nchk);
   endtask

   task automatic wait_done(output int bc);
      int t = 0;
      bc = 0;
      while (!done && t < 2000) begin
         if (busy) bc++;
         @(negedge clk);
         t++;
      end
      chk("R9 done seen", 32'(done), 32'd1);
   endtask

   task automatic pulse(input logic b, input logic brk, input logic rr);
      boundary = b; brk_req = brk; reset_req = rr;
      @(negedge clk);
      boundary = 1'b0; brk_req = 1'b0; reset_req = 1'b0;
   endtask

   // table: kind(2) pc(16) sp(8) psr(8) wait(2); kind 0 rst,1 nmi,2 brk,3 irq
   localparam int NT = 6;
   localparam logic [35:0] TBL [NT] = '{
      {2'd3, 16'h8123, 8'hFD, 8'h00, 2'd0},
      {2'd1, 16'hC0FE, 8'h02, 8'hC3, 2'd1},
      {2'd2, 16'h0001, 8'h80, 8'h24, 2'd2},
      {2'd0, 16'h1234, 8'h01, 8'h00, 2'd1},
      {2'd1, 16'hFFFF, 8'h00, 8'h34, 2'd0},
      {2'd3, 16'h7F80, 8'hFF, 8'hCB, 2'd3}
   };

   initial begin
      repeat (200000) @(posedge clk);
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      int bc;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 power-up values
      chk("R1 busy", 32'(busy), 0);
      chk("R1 done", 32'(done), 0);
      chk("R1 mem_req", 32'(mem_req), 0);
      chk("R1 new_psr", 32'(new_psr), 32'h34);
      chk("R1 new_sp", 32'(new_sp), 32'hFD);

      for (int i = 0; i < NT; i++) begin
         logic [1:0]  kind;
         logic [15:0] pc, vl;
         logic [7:0]  sp, psr;
         int          ws;
         kind = TBL[i][35:34]; pc = TBL[i][33:18]; sp = TBL[i][17:10];
         psr = TBL[i][9:2]; ws = int'(TBL[i][1:0]);
         ws_cfg = ws; nlog = 0;
         cur_pc = pc; cur_sp = sp; cur_psr = psr;
         case (kind)
            2'd0: pulse(1'b0, 1'b0, 1'b1);
            2'd1: begin nmi_n = 1'b0; @(negedge clk); pulse(1'b1, 1'b0, 1'b0); end
            2'd2: pulse(1'b1, 1'b1, 1'b0);
            default: begin irq_n = 1'b0; pulse(1'b1, 1'b0, 1'b0); end
         endcase
         wait_done(bc);
         vl = (kind == 2'd0) ? 16'hFFFC : (kind == 2'd1) ? 16'hFFFA : 16'hFFFE;
         chk("R13 entry_src", 32'(entry_src), 32'(kind));
         chk("R6 new_pc", 32'(new_pc), 32'({mem_val(vl | 16'h1), mem_val(vl)}));
         chk("R7 new_psr", 32'(new_psr), 32'(psr | 8'h04));
         chk("R9 busy cycles", bc, (kind == 2'd0) ? 2 * (ws + 1) : 5 * (ws + 1));
         chk("R9 busy low at done", 32'(busy), 0);
         if (kind == 2'd0) begin
            chk("R8 new_sp", 32'(new_sp), 32'(8'(sp - 8'd3)));
            chk("R8 no writes", nlog, 0);
         end else begin
            chk("R5 new_sp", 32'(new_sp), 32'(8'(sp - 8'd3)));
            chk("R5 write count", nlog, 3);
            for (int k = 0; k < 3; k++)
               chk("R5 write addr", 32'(log_a[k]), 32'({8'h01, 8'(sp - 8'(k))}));
            chk("R5 data pc hi", 32'(log_d[0]), 32'(pc[15:8]));
            chk("R5 data pc lo", 32'(log_d[1]), 32'(pc[7:0]));
            chk("R5 data status", 32'(log_d[2]), 32'(psr | 8'h30));
         end
         nmi_n = 1'b1; irq_n = 1'b1;
         @(negedge clk);
         chk("R9 done single pulse", 32'(done), 0);
      end

      // R4: pending NMI without boundary is not taken
      ws_cfg = 1; cur_psr = 8'h00; cur_sp = 8'hFD; cur_pc = 16'h4000;
      nmi_n = 1'b0;
      repeat (3) @(negedge clk);
      chk("R4 no entry without boundary", 32'(busy), 0);
      // R4: NMI wins over break and IRQ at the same boundary
      irq_n = 1'b0;
      pulse(1'b1, 1'b1, 1'b0);
      chk("R4 busy after accept", 32'(busy), 1);
      chk("R4 NMI beats break and IRQ", 32'(entry_src), 1);
      // R12: new falling edge during entry
      nmi_n = 1'b1; @(negedge clk); nmi_n = 1'b0;
      wait_done(bc);
      pulse(1'b1, 1'b0, 1'b0);
      chk("R12 re-latched NMI taken", 32'(entry_src), 1);
      chk("R12 busy", 32'(busy), 1);
      wait_done(bc);
      // R2: line still low, no retrigger; R4: IRQ now served
      pulse(1'b1, 1'b0, 1'b0);
      chk("R4 IRQ after NMI served", 32'(entry_src), 3);
      wait_done(bc);
      irq_n = 1'b1;
      @(negedge clk);
      pulse(1'b1, 1'b0, 1'b0);
      chk("R2 held-low NMI no retrigger", 32'(busy), 0);
      nmi_n = 1'b1;
      @(negedge clk);

      // R3: IRQ masked by status bit 2
      cur_psr = 8'h04; irq_n = 1'b0;
      pulse(1'b1, 1'b0, 1'b0);
      chk("R3 masked IRQ ignored", 32'(busy), 0);
      repeat (2) @(negedge clk);
      chk("R3 no bus request", 32'(mem_req), 0);
      irq_n = 1'b1; cur_psr = 8'h00;
      @(negedge clk);

      // R4: reset request beats pending NMI and break
      nmi_n = 1'b0; @(negedge clk);
      pulse(1'b1, 1'b1, 1'b1);
      chk("R4 reset beats NMI", 32'(entry_src), 0);
      wait_done(bc);
      pulse(1'b1, 1'b0, 1'b0);
      chk("R4 NMI kept pending after reset", 32'(entry_src), 1);
      wait_done(bc);
      nmi_n = 1'b1;
      @(negedge clk);

      // R11: restore masking
      pulled_psr = 8'hFF; cur_psr = 8'h00; #1;
      chk("R11 restore 1", 32'(restored_psr), 32'hCF);
      pulled_psr = 8'h00; cur_psr = 8'h30; #1;
      chk("R11 restore 2", 32'(restored_psr), 32'h30);
      pulled_psr = 8'hA5; cur_psr = 8'h10; #1;
      chk("R11 restore 3", 32'(restored_psr), 32'h95);

      summary();
      $finish;
   end

endmodule